// File: doc/BRIEF.md
# Multi-PHY Cell Transmit Slave

This block is the PHY-side end of a shared cell transmit bus. One ATM-layer master drives a 16-bit data bus, a 5-bit device address bus, an active-low write enable, a start-of-cell marker and an odd-parity bit to several PHY devices. The master polls devices by placing their address on the bus, and each one answers with a cell-available flag. It selects one device for writing by placing that device's address on the bus during the last clock on which the write enable is still high. From then on, every word written with the enable low goes to that device. The master may keep polling other addresses, including the null address 1Fh, while it writes.

After selection the block delineates cells of 27 words by the start-of-cell marker and builds each cell in a FIFO slot of its own. A cell is made visible to the downstream reader only after its last word has arrived intact. Three single-cycle event pulses report odd-parity violations, runt cells (a start-of-cell that arrives before the current cell is complete) and words that arrive while every FIFO slot is in use. An optional mode drops any cell that carries a parity error, and a clear input empties the FIFO. The downstream side reads the stored words one at a time.

Top module: `cell_tx_slave`

## Requirements
- R1: The block accepts a word on a rising edge where `tx_wr_n` is 0 only if one of two conditions holds. Either the previous edge had `tx_wr_n` = 1 and `tx_addr` = `MY_ADDR`, or the previous edge also had `tx_wr_n` = 0 and the block was selected. On an edge where `tx_wr_n` is 1 with any other address, the block ends up deselected for the next burst of writes.
- R2: The null address 1Fh never selects the block. It counts as an address that is not this block's own.
- R3: Addresses placed on `tx_addr` while `tx_wr_n` is 0 (polling) do not change the selection, and they do not disturb the cell in progress.
- R4: `cell_avail` is registered. It is 1 in the cycle after an edge where `tx_addr` = `MY_ADDR` only if the count of stored cells plus one for a cell in progress is below `FIFO_CELLS`. It is 0 after every other edge.
- R5: A word with `tx_soc` = 1 starts a cell at word index 0. The cell is committed to the FIFO when its 27th word is accepted. An accepted word with `tx_soc` = 0 while no cell is in progress is not stored.
- R6: Parity is odd: the XOR of `tx_data` and `tx_par` must be 1. An accepted word that breaks this raises `evt_parity` for exactly the cycle after its edge.
- R7: A word with `tx_soc` = 1 that arrives while a cell is in progress raises `evt_align` in the cycle after its edge. The partial cell is dropped, and the new word becomes word 0 of a new cell.
- R8: A word that belongs to a cell and arrives while `FIFO_CELLS` cells are stored raises `evt_overrun` in the next cycle. The word is not stored, and the cell it belongs to is never committed.
- R9: While `drop_on_perr` is 1 at the edge of a cell's last word, a cell that contains any parity error is not committed. While it is 0, such a cell is stored with its words unchanged.
- R10: `fifo_clear` = 1 at an edge empties the FIFO and drops the cell in progress. In the next cycle `rd_valid` is 0.
- R11: `rd_valid` is 1 while at least one whole cell is stored. `rd_data` shows the oldest unread word, and `rd_soc` is 1 on word 0. `rd_en` = 1 at an edge with `rd_valid` = 1 advances one word. Cells leave in the order they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr_n | input | 1 | Active-low write enable from the master |
| tx_addr | input | 5 | Poll and select address |
| tx_data | input | 16 | Cell word |
| tx_par | input | 1 | Odd parity bit over tx_data |
| tx_soc | input | 1 | Marks word 0 of a cell |
| drop_on_perr | input | 1 | Drop cells that contain a parity error |
| fifo_clear | input | 1 | Empties the cell FIFO |
| cell_avail | output | 1 | Poll answer: room for a whole cell |
| evt_parity | output | 1 | Parity error pulse |
| evt_align | output | 1 | Runt cell pulse |
| evt_overrun | output | 1 | Word dropped because the FIFO is full |
| rd_en | input | 1 | Reader takes the current word |
| rd_data | output | 16 | Oldest unread word |
| rd_soc | output | 1 | rd_data is word 0 of a cell |
| rd_valid | output | 1 | A whole cell is stored |

## Verification
The bench builds the block with `FIFO_CELLS` = 2 and `MY_ADDR` = 02h, and keeps the 27-word cell and the 16-bit bus. With only two slots, the full FIFO, the overrun pulse and the `cell_avail` drop during a cell in progress all come up within a few cells. This lets the random phase hit the full and nearly full states many times among its runts, parity errors and polls of foreign and null addresses. Because `MY_ADDR` is not 00h or 1Fh, selection by the null address and by a foreign address can each be told apart from selection of the block's own address.

// File: rtl/cts_pkg.sv
// Shared definitions for the cell transmit slave.
// Assumes a 5-bit device address space in which the all-ones value is the null device.
package cts_pkg;
    localparam logic [4:0] CTS_NULL_ADDR = 5'h1F;

    // Per-word error events, registered one cycle after the word's edge.
    typedef struct packed {
        logic parity;
        logic align;
        logic overrun;
    } cts_evt_t;
endpackage

// File: rtl/cts_select.sv
// Selection tracker: decides whether an enabled word belongs to this device.
// Assumes the selection address is the one seen on the last edge with the
// write enable high; addresses seen while it is low are polls only.
module cts_select #(
    parameter int         ADDR_W  = 5,
    parameter logic [4:0] MY_ADDR = 5'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              word_ok,
    output logic              own_addr
);
    logic prev_idle;
    logic hit_q;
    logic sel_q;

    // Own address, never the null address.
    assign own_addr = (addr == ADDR_W'(MY_ADDR)) && (addr != ADDR_W'(cts_pkg::CTS_NULL_ADDR));
    assign word_ok  = !wr_n && (prev_idle ? hit_q : sel_q);

    // Remember the address of the last idle edge and commit it on the first enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_idle <= 1'b0;
            hit_q     <= 1'b0;
            sel_q     <= 1'b0;
        end else begin
            prev_idle <= wr_n;
            if (wr_n) begin
                hit_q <= own_addr;
            end else if (prev_idle) begin
                sel_q <= hit_q;
            end
        end
    end
endmodule

// File: rtl/cts_cell_framer.sv
// Cell framer: counts words from start-of-cell, checks odd parity, tracks
// per-cell error state and decides whether a finished cell is committed.
// Assumes the FIFO gives a stable full flag for the whole edge.
module cts_cell_framer
    import cts_pkg::*;
#(
    parameter int  DATA_W     = 16,
    parameter int  CELL_WORDS = 27,
    localparam int IDX_W      = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_ok,
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    input  logic              soc,
    input  logic              drop_on_perr,
    input  logic              clear,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              commit,
    output logic              busy,
    output cts_evt_t          evt
);
    logic [IDX_W-1:0] wcnt;
    logic             bad_q;
    logic             perr_q;
    logic             perr;
    logic             take;
    logic             last;
    logic             cell_bad;
    logic             cell_perr;

    assign busy      = (wcnt != '0);
    assign perr      = ~(^{data, par});
    assign wr_idx    = soc ? '0 : wcnt;
    assign last      = (wr_idx == IDX_W'(CELL_WORDS - 1));
    assign take      = word_ok && (soc || busy) && !clear;
    assign cell_bad  = (!soc && bad_q) || fifo_full;
    assign cell_perr = (!soc && perr_q) || perr;
    assign wr_en     = take && !fifo_full;
    assign commit    = take && last && !cell_bad && !(drop_on_perr && cell_perr);

    // Word counter, per-cell error state and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wcnt   <= '0;
            bad_q  <= 1'b0;
            perr_q <= 1'b0;
            evt    <= '0;
        end else begin
            evt.parity  <= word_ok && perr;
            evt.align   <= take && soc && busy;
            evt.overrun <= take && fifo_full;
            if (take) begin
                wcnt   <= last ? '0 : wr_idx + 1'b1;
                bad_q  <= cell_bad;
                perr_q <= cell_perr;
            end
        end
    end
endmodule

// File: rtl/cts_cell_fifo.sv
// Cell FIFO: one slot per cell; a cell is written into the slot after the
// committed ones and becomes readable only on commit. Reads are word by word.
// Assumes the writer never writes while the FIFO is full.
module cts_cell_fifo #(
    parameter int  DATA_W     = 16,
    parameter int  CELL_WORDS = 27,
    parameter int  FIFO_CELLS = 4,
    localparam int IDX_W      = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1,
    localparam int PTR_W      = (FIFO_CELLS > 1) ? $clog2(FIFO_CELLS) : 1,
    localparam int CNT_W      = $clog2(FIFO_CELLS + 1),
    localparam int DEPTH      = FIFO_CELLS * CELL_WORDS,
    localparam int MEM_AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_soc,
    output logic              rd_valid,
    output logic              full,
    output logic [CNT_W-1:0]  level
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_cell;
    logic [PTR_W-1:0]  rd_cell;
    logic [IDX_W-1:0]  rd_word;
    logic [MEM_AW-1:0] wr_addr;
    logic [MEM_AW-1:0] rd_addr;
    logic              pop;
    logic              pop_last;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(FIFO_CELLS - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_addr  = MEM_AW'(wr_cell) * MEM_AW'(CELL_WORDS) + MEM_AW'(wr_idx);
    assign rd_addr  = MEM_AW'(rd_cell) * MEM_AW'(CELL_WORDS) + MEM_AW'(rd_word);
    assign full     = (level == CNT_W'(FIFO_CELLS));
    assign rd_valid = (level != '0);
    assign rd_data  = mem[rd_addr];
    assign rd_soc   = (rd_word == '0);
    assign pop      = rd_en && rd_valid;
    assign pop_last = pop && (rd_word == IDX_W'(CELL_WORDS - 1));

    // Word storage; no reset needed since only committed slots are read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Slot pointers, read word index and stored cell count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_cell <= '0;
            rd_cell <= '0;
            rd_word <= '0;
            level   <= '0;
        end else begin
            if (commit) begin
                wr_cell <= next_ptr(wr_cell);
            end
            if (pop) begin
                rd_word <= pop_last ? '0 : rd_word + 1'b1;
                if (pop_last) begin
                    rd_cell <= next_ptr(rd_cell);
                end
            end
            level <= level + CNT_W'(commit) - CNT_W'(pop_last);
        end
    end
endmodule

// File: rtl/cell_tx_slave.sv
// Multi-PHY cell transmit slave: selection, poll answer, cell framing with
// parity, runt and overrun events, and a cell FIFO toward the line side.
// Assumes MY_ADDR is not the null address (such a setting never selects).
module cell_tx_slave
    import cts_pkg::*;
#(
    parameter int         DATA_W     = 16,
    parameter int         ADDR_W     = 5,
    parameter int         CELL_WORDS = 27,
    parameter int         FIFO_CELLS = 4,
    parameter logic [4:0] MY_ADDR    = 5'h02,
    localparam int        IDX_W      = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1,
    localparam int        CNT_W      = $clog2(FIFO_CELLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr_n,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_par,
    input  logic              tx_soc,
    input  logic              drop_on_perr,
    input  logic              fifo_clear,
    output logic              cell_avail,
    output logic              evt_parity,
    output logic              evt_align,
    output logic              evt_overrun,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_soc,
    output logic              rd_valid
);
    logic             word_ok;
    logic             own_addr;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             commit;
    logic             busy;
    logic             full;
    logic [CNT_W-1:0] level;
    cts_evt_t         evt;

    cts_select #(
        .ADDR_W  (ADDR_W),
        .MY_ADDR (MY_ADDR)
    ) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (tx_wr_n),
        .addr     (tx_addr),
        .word_ok  (word_ok),
        .own_addr (own_addr)
    );

    cts_cell_framer #(
        .DATA_W     (DATA_W),
        .CELL_WORDS (CELL_WORDS)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_ok      (word_ok),
        .data         (tx_data),
        .par          (tx_par),
        .soc          (tx_soc),
        .drop_on_perr (drop_on_perr),
        .clear        (fifo_clear),
        .fifo_full    (full),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .commit       (commit),
        .busy         (busy),
        .evt          (evt)
    );

    cts_cell_fifo #(
        .DATA_W     (DATA_W),
        .CELL_WORDS (CELL_WORDS),
        .FIFO_CELLS (FIFO_CELLS)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (fifo_clear),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (tx_data),
        .commit   (commit),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_soc   (rd_soc),
        .rd_valid (rd_valid),
        .full     (full),
        .level    (level)
    );

    assign evt_parity  = evt.parity;
    assign evt_align   = evt.align;
    assign evt_overrun = evt.overrun;

    // Poll answer: room for one more whole cell beside stored and in-progress ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_avail <= 1'b0;
        end else begin
            cell_avail <= own_addr && ((int'(level) + int'(busy)) < FIFO_CELLS);
        end
    end
endmodule

// File: rtl/cts_checker.sv
// Property checker for the cell transmit slave, bound to every instance.
// Assumes the signal names of cell_tx_slave.
module cts_checker #(
    parameter int         ADDR_W     = 5,
    parameter int         DATA_W     = 16,
    parameter int         FIFO_CELLS = 4,
    parameter logic [4:0] MY_ADDR    = 5'h02,
    parameter int         CNT_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_wr_n,
    input logic [ADDR_W-1:0] tx_addr,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_par,
    input logic              tx_soc,
    input logic              fifo_clear,
    input logic              cell_avail,
    input logic              evt_parity,
    input logic              evt_align,
    input logic              evt_overrun,
    input logic              rd_valid,
    input logic              word_ok,
    input logic              busy,
    input logic [CNT_W-1:0]  level
);
    // R1 R2: a first enabled word is taken only after the own address on the idle edge.
    assert_select_own_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && $past(tx_wr_n)) |-> ($past(tx_addr) == ADDR_W'(MY_ADDR)));

    // R4: the poll answer follows a poll of the own address.
    assert_avail_own_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cell_avail |-> ($past(tx_addr) == ADDR_W'(MY_ADDR)));

    // R4: the poll answer means a whole slot was free.
    assert_avail_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cell_avail |-> ((int'($past(level)) + int'($past(busy))) < FIFO_CELLS));

    // R6: a parity pulse follows an accepted word with even parity.
    assert_parity_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_parity |-> ($past(word_ok) && !$past(^{tx_data, tx_par})));

    // R7: an alignment pulse follows a start-of-cell inside a cell.
    assert_align_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_align |-> $past(word_ok && tx_soc && busy));

    // R8: an overrun pulse follows a word written while every slot was in use.
    assert_overrun_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_overrun |-> ($past(level) == CNT_W'(FIFO_CELLS)));

    // R8: the stored cell count never exceeds the slot count.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= FIFO_CELLS);

    // R10: a clear leaves nothing readable.
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> !rd_valid);
endmodule

bind cell_tx_slave cts_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .FIFO_CELLS (FIFO_CELLS),
    .MY_ADDR    (MY_ADDR),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_wr_n     (tx_wr_n),
    .tx_addr     (tx_addr),
    .tx_data     (tx_data),
    .tx_par      (tx_par),
    .tx_soc      (tx_soc),
    .fifo_clear  (fifo_clear),
    .cell_avail  (cell_avail),
    .evt_parity  (evt_parity),
    .evt_align   (evt_align),
    .evt_overrun (evt_overrun),
    .rd_valid    (rd_valid),
    .word_ok     (word_ok),
    .busy        (busy),
    .level       (level)
);

// File: tb/cell_tx_slave_tb.sv
// Self-checking bench: directed corners, then seeded random cells, against a
// bench-side model of selection, framing and the cell FIFO.
module cell_tx_slave_tb;
    localparam int         CW    = 27;
    localparam int         NCELL = 2;
    localparam logic [4:0] MY    = 5'h02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_wr_n = 1'b1;
    logic [4:0]  tx_addr = 5'h1F;
    logic [15:0] tx_data = '0;
    logic        tx_par = 1'b0;
    logic        tx_soc = 1'b0;
    logic        drop_on_perr = 1'b0;
    logic        fifo_clear = 1'b0;
    logic        rd_en = 1'b0;
    logic        cell_avail, evt_parity, evt_align, evt_overrun;
    logic [15:0] rd_data;
    logic        rd_soc, rd_valid;

    int checks = 0;
    int errors = 0;

    // Model state.
    bit          m_prev_high = 0;
    bit          m_hit = 0;
    bit          m_sel = 0;
    int          m_w = 0;
    bit          m_bad = 0;
    bit          m_perr = 0;
    int          mcnt = 0;
    logic [15:0] cur[$];
    logic [15:0] exp_q[$];

    cell_tx_slave #(
        .FIFO_CELLS (NCELL),
        .MY_ADDR    (MY)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_wr_n      (tx_wr_n),
        .tx_addr      (tx_addr),
        .tx_data      (tx_data),
        .tx_par       (tx_par),
        .tx_soc       (tx_soc),
        .drop_on_perr (drop_on_perr),
        .fifo_clear   (fifo_clear),
        .cell_avail   (cell_avail),
        .evt_parity   (evt_parity),
        .evt_align    (evt_align),
        .evt_overrun  (evt_overrun),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .rd_soc       (rd_soc),
        .rd_valid     (rd_valid)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_avail(input logic [4:0] a);
        return (a == MY) && ((mcnt + ((m_w != 0) ? 1 : 0)) < NCELL);
    endfunction

    // Idle cycle with the enable high; the address is a poll and a selection candidate.
    task automatic idle(input logic [4:0] a);
        bit ea;
        tx_wr_n = 1'b1;
        tx_addr = a;
        tx_soc  = 1'b0;
        ea = exp_avail(a);
        m_prev_high = 1;
        m_hit = (a == MY);
        @(negedge clk);
        check("R4 poll answer", cell_avail, ea);
        check("R6 no parity pulse when idle", evt_parity, 0);
    endtask

    // One enabled word; poll < 0 picks a random poll address.
    task automatic write_word(input logic [15:0] d, input bit soc, input bit bad_par, input int poll);
        logic [4:0] a;
        bit eff, ea, ep, eal, eov, full;
        a = (poll < 0) ? 5'($urandom_range(0, 31)) : 5'(poll);
        tx_wr_n = 1'b0;
        tx_addr = a;
        tx_data = d;
        tx_soc  = soc;
        tx_par  = bad_par ? (^d) : ~(^d);
        ea = exp_avail(a);
        eff = m_prev_high ? m_hit : m_sel;
        m_sel = eff;
        m_prev_high = 0;
        ep = 0; eal = 0; eov = 0;
        if (eff) begin
            ep = bad_par;
            if (soc || m_w != 0) begin
                full = (mcnt == NCELL);
                if (soc) begin
                    eal = (m_w != 0);
                    m_w = 0;
                    cur.delete();
                    m_bad = 0;
                    m_perr = 0;
                end
                eov = full;
                m_bad = m_bad | full;
                m_perr = m_perr | bad_par;
                cur.push_back(d);
                m_w++;
                if (m_w == CW) begin
                    if (!m_bad && !(drop_on_perr && m_perr)) begin
                        foreach (cur[i]) exp_q.push_back(cur[i]);
                        mcnt++;
                    end
                    m_w = 0;
                    cur.delete();
                end
            end
        end
        @(negedge clk);
        check("R4 poll answer during write (R3)", cell_avail, ea);
        check("R6 parity pulse", evt_parity, ep);
        check("R7 alignment pulse", evt_align, eal);
        check("R8 overrun pulse", evt_overrun, eov);
    endtask

    // A cell of n words starting with start-of-cell; bad_at < 0 means no parity error.
    task automatic send_cell(input int n, input int bad_at, input int poll);
        for (int i = 0; i < n; i++) begin
            write_word(16'($urandom), (i == 0), (i == bad_at), poll);
        end
        idle(MY);
    endtask

    // Reads one stored cell and compares it with the model.
    task automatic read_cell();
        for (int i = 0; i < CW; i++) begin
            check("R11 rd_valid during cell", rd_valid, 1);
            check("R11 rd_soc position", rd_soc, (i == 0) ? 1 : 0);
            check("R5 R11 stored word", rd_data, (exp_q.size() > 0) ? exp_q[0] : 0);
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        mcnt--;
    endtask

    task automatic read_all();
        while (mcnt > 0) read_cell();
        check("R11 rd_valid after drain", rd_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_CE11));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset rd_valid", rd_valid, 0);
        check("R4 reset cell_avail", cell_avail, 0);
        check("R8 reset overrun", evt_overrun, 0);

        // R4: polls of own, foreign and null addresses.
        idle(5'h05);
        idle(5'h1F);
        idle(MY);

        // R1 R3: select own address, write while polling the null address.
        send_cell(CW, -1, 31);
        check("R5 one full cell stored", rd_valid, 1);
        read_all();

        // R1: select another device, then write: nothing lands here.
        idle(5'h05);
        send_cell(CW, -1, 0);
        check("R1 foreign selection stores nothing", rd_valid, 0);

        // R2: the null address never selects.
        idle(5'h1F);
        send_cell(CW, -1, 2);
        check("R2 null selection stores nothing", rd_valid, 0);

        // R5: stray words without start-of-cell are not stored.
        idle(MY);
        for (int i = 0; i < 5; i++) write_word(16'h1234 + 16'(i), 1'b0, 1'b0, 3);
        idle(MY);
        check("R5 stray words not stored", rd_valid, 0);

        // R6 R9: parity error kept when discard is off, dropped when on.
        drop_on_perr = 1'b0;
        send_cell(CW, 5, -1);
        check("R9 bad cell kept without discard", rd_valid, 1);
        read_all();
        drop_on_perr = 1'b1;
        send_cell(CW, 26, -1);
        check("R9 bad cell dropped with discard", rd_valid, 0);
        drop_on_perr = 1'b0;

        // R7: runt then full cell.
        send_cell(10, -1, -1);
        send_cell(CW, -1, -1);
        check("R7 only the full cell remains", mcnt, 1);
        read_all();

        // R8: fill both slots, then one more cell overruns.
        send_cell(CW, -1, 2);
        send_cell(CW, -1, 2);
        send_cell(CW, -1, 2);
        check("R8 two cells stored after overrun", mcnt, 2);
        read_all();

        // R10: clear with a stored cell and a cell in progress.
        send_cell(CW, -1, -1);
        send_cell(7, -1, -1);
        fifo_clear = 1'b1;
        @(negedge clk);
        fifo_clear = 1'b0;
        mcnt = 0; exp_q.delete(); cur.delete(); m_w = 0; m_bad = 0; m_perr = 0;
        check("R10 clear empties FIFO", rd_valid, 0);
        idle(MY);

        // Random phase.
        for (int it = 0; it < 60; it++) begin
            int n, bad_at;
            drop_on_perr = 1'($urandom_range(0, 1));
            n = ($urandom_range(0, 5) == 0) ? $urandom_range(1, CW - 1) : CW;
            bad_at = ($urandom_range(0, 3) == 0) ? $urandom_range(0, n - 1) : -1;
            if ($urandom_range(0, 7) == 0) idle(5'($urandom_range(3, 31)));
            else idle(MY);
            send_cell(n, bad_at, -1);
            if ($urandom_range(0, 2) == 0 || mcnt == NCELL) read_all();
        end
        read_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule